// File: doc/BRIEF.md
# Four-Line Track Slope Classifier

This block watches four neighbouring detector lines of a pixel readout. Each line gives one hit bit per bunch-crossing clock. A line keeps a sliding window of its last eight samples, and the number of set samples in that window is the line's occupancy. The four occupancies are added into one total. A track is reported on the clock where that total first climbs from below the track threshold to the threshold or above. A total that stays high does not report a second track.

With each report the block gives four things. The first is a slope code that says which lines have hits in their windows. A steep, high-momentum track lights only the first line, and a shallow, low-momentum track spreads over all four. The second is the bunch-crossing number of the earliest hit still inside any window. The third is the index of the line that holds that earliest hit. The fourth is a one-clock valid strobe. A bunch-crossing number of zero is reserved and means no hit, so the counter that feeds the block must skip zero.

The line count, window length, bunch-crossing width and threshold are parameters. The defaults are 4 lines, an 8-crossing window, 12 bits and a threshold of 7.

Top module: `track_slope_classifier`

## Requirements
- R1: A synchronous reset clears every line window and all outputs. Hits sampled before a reset never add to a total after it.
- R2: The occupancy of a line is the number of its hit samples among the last WIN clock edges, so it is at most WIN. A hit stays in the window for exactly WIN edges.
- R3: The valid strobe is high for exactly one clock, and only when the previous total was below THR and the new total is THR or more. A total that stays at or above THR gives no further strobe.
- R4: While the valid strobe is low, the slope code, the bunch-crossing output and the line index are all zero.
- R5: On a report, the slope code depends on the occupied lines, where bit n of the pattern is line n. Only line 0 gives 1, lines 0 and 1 give 2, lines 0 to 2 give 3, and all four give 4.
- R6: On a report, any other occupied pattern (one that is not a run starting at line 0) gives slope code 5.
- R7: On a report, the bunch-crossing output is the smallest non-zero crossing number among the oldest in-window hits of the lines.
- R8: On a report, the line index names the line that holds the crossing number of R7. When lines tie, the lowest index wins.
- R9: A hit sampled at clock edge k can raise the valid strobe no earlier than the register update at edge k+1.
- R10: After hits leave the windows and the total falls below THR, a new upward crossing reports a new track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | NLINES | One hit bit per line, sampled on every rising edge |
| bx_i | input | BXW | Current bunch-crossing number, never zero |
| track_valid_o | output | 1 | One-clock strobe for a track report |
| track_id_o | output | $clog2(NLINES+2) | Slope code: 0 none, 1..NLINES regular, NLINES+1 irregular |
| track_bx_o | output | BXW | Crossing number of the earliest in-window hit |
| track_line_o | output | $clog2(NLINES) | Line that holds that earliest hit |

## Verification
The total is known right after the edge that samples a hit. The report registers capture it at the next edge. So when the threshold-crossing hit is driven in step k, its report is seen at the falling edge that follows edge k+1 and not before. The bench model keeps this timing. On each rising edge it works out the expected outputs from its history queues as they stood before that edge, and then adds the new sample. The outputs are compared at every falling edge. The directed cases add checks at fixed steps: one step before the report (expect no strobe), at the report step, and one step after it (the strobe must be gone).

// File: rtl/trk_pkg.sv
package trk_pkg;

   localparam int unsigned SLOPE_NONE = 0;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return $clog2(max_val + 1);
   endfunction

   function automatic int unsigned slope_bits(input int unsigned lines);
      return $clog2(lines + 2);
   endfunction

endpackage

// File: rtl/line_window.sv
module line_window #(
   parameter int WIN = 8,
   parameter int BXW = 12,
   localparam int CW = trk_pkg::cnt_bits(WIN)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           hit_i,
   input  logic [BXW-1:0] bx_i,
   output logic [CW-1:0]  cnt_o,
   output logic [BXW-1:0] first_bx_o
);

   if (WIN < 2) begin : g_chk_win
      $error("line_window: WIN must be at least 2");
   end
   if (BXW < 2) begin : g_chk_bxw
      $error("line_window: BXW must be at least 2");
   end

   logic [WIN-1:0] win_q;
   logic [BXW-1:0] bx_q [WIN];
   logic           seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q <= '0;
         for (int i = 0; i < WIN; i++) bx_q[i] <= '0;
      end else begin
         win_q   <= {win_q[WIN-2:0], hit_i};
         bx_q[0] <= bx_i;
         for (int i = 1; i < WIN; i++) bx_q[i] <= bx_q[i-1];
      end
   end

   always_ff @(posedge clk) seen_q <= !rst;

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < WIN; i++) cnt_o = cnt_o + CW'(win_q[i]);
   end

   always_comb begin
      first_bx_o = '0;
      for (int i = 0; i < WIN; i++) begin
         if (win_q[i]) first_bx_o = bx_q[i];
      end
   end

   AST_HIT_NO_DROP: assert property (@(posedge clk) disable iff (rst || !seen_q)
      $past(hit_i) |-> cnt_o >= $past(cnt_o)); // R2
   AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (rst || !seen_q)
      !$past(hit_i) |-> cnt_o <= $past(cnt_o)); // R2

endmodule

// File: rtl/slope_resolver.sv
module slope_resolver #(
   parameter int NLINES = 4,
   parameter int WIN    = 8,
   parameter int BXW    = 12,
   localparam int CW    = trk_pkg::cnt_bits(WIN),
   localparam int IDW   = trk_pkg::slope_bits(NLINES),
   localparam int LW    = $clog2(NLINES)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [CW-1:0]  cnt_i [NLINES],
   input  logic [BXW-1:0] fb_i  [NLINES],
   output logic [IDW-1:0] id_o,
   output logic [BXW-1:0] bx_o,
   output logic [LW-1:0]  line_o
);

   localparam logic [IDW-1:0] ID_IRREG = IDW'(NLINES + 1);

   logic [NLINES-1:0] nz;
   logic [NLINES-1:0] run_mask;
   logic              seen_q;
   int                run_len;
   logic              in_run;
   logic              found;

   always_comb begin
      in_run  = 1'b1;
      run_len = 0;
      for (int l = 0; l < NLINES; l++) begin
         nz[l] = (cnt_i[l] != '0);
         if (in_run && nz[l]) run_len = run_len + 1;
         else in_run = 1'b0;
      end
      for (int l = 0; l < NLINES; l++) run_mask[l] = (l < run_len);
      if (nz == '0)            id_o = IDW'(trk_pkg::SLOPE_NONE);
      else if (nz == run_mask) id_o = IDW'(run_len);
      else                     id_o = ID_IRREG;
   end

   always_comb begin
      found  = 1'b0;
      bx_o   = '0;
      line_o = '0;
      for (int l = 0; l < NLINES; l++) begin
         if (fb_i[l] != '0 && (!found || fb_i[l] < bx_o)) begin
            found  = 1'b1;
            bx_o   = fb_i[l];
            line_o = LW'(l);
         end
      end
   end

   always_ff @(posedge clk) seen_q <= !rst;

   AST_LINE_OCCUPIED: assert property (@(posedge clk) disable iff (rst || !seen_q)
      (bx_o != '0) |-> (cnt_i[line_o] != '0)); // R8

endmodule

// File: rtl/track_slope_classifier.sv
module track_slope_classifier #(
   parameter int NLINES = 4,
   parameter int WIN    = 8,
   parameter int BXW    = 12,
   parameter int THR    = 7,
   localparam int IDW   = trk_pkg::slope_bits(NLINES),
   localparam int LW    = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NLINES-1:0] hit_i,
   input  logic [BXW-1:0]    bx_i,
   output logic              track_valid_o,
   output logic [IDW-1:0]    track_id_o,
   output logic [BXW-1:0]    track_bx_o,
   output logic [LW-1:0]     track_line_o
);

   localparam int CW = trk_pkg::cnt_bits(WIN);
   localparam int SW = trk_pkg::cnt_bits(NLINES * WIN);
   localparam logic [SW-1:0] THR_V = SW'(THR);

   if (NLINES < 2) begin : g_chk_lines
      $error("track_slope_classifier: NLINES must be at least 2");
   end
   if (THR < 1 || THR > NLINES * WIN) begin : g_chk_thr
      $error("track_slope_classifier: THR out of range");
   end

   logic [CW-1:0]  cnt_w [NLINES];
   logic [BXW-1:0] fb_w  [NLINES];
   logic [SW-1:0]  total_w;
   logic [SW-1:0]  prev_q;
   logic           fire_w;
   logic [IDW-1:0] res_id;
   logic [BXW-1:0] res_bx;
   logic [LW-1:0]  res_line;
   logic           seen_q;

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      line_window #(.WIN(WIN), .BXW(BXW)) u_win (
         .clk       (clk),
         .rst       (rst),
         .hit_i     (hit_i[g]),
         .bx_i      (bx_i),
         .cnt_o     (cnt_w[g]),
         .first_bx_o(fb_w[g])
      );
   end

   slope_resolver #(.NLINES(NLINES), .WIN(WIN), .BXW(BXW)) u_res (
      .clk   (clk),
      .rst   (rst),
      .cnt_i (cnt_w),
      .fb_i  (fb_w),
      .id_o  (res_id),
      .bx_o  (res_bx),
      .line_o(res_line)
   );

   always_comb begin
      total_w = '0;
      for (int l = 0; l < NLINES; l++) total_w = total_w + SW'(cnt_w[l]);
   end

   assign fire_w = (prev_q < THR_V) && (total_w >= THR_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q        <= '0;
         track_valid_o <= 1'b0;
         track_id_o    <= '0;
         track_bx_o    <= '0;
         track_line_o  <= '0;
      end else begin
         prev_q        <= total_w;
         track_valid_o <= fire_w;
         track_id_o    <= fire_w ? res_id   : '0;
         track_bx_o    <= fire_w ? res_bx   : '0;
         track_line_o  <= fire_w ? res_line : '0;
      end
   end

   always_ff @(posedge clk) seen_q <= !rst;

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      track_valid_o |=> !track_valid_o); // R3
   AST_FIRE_ABOVE_THR: assert property (@(posedge clk) disable iff (rst || !seen_q)
      track_valid_o |-> $past(total_w >= THR_V)); // R3
   AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
      !track_valid_o |-> (track_id_o == '0 && track_bx_o == '0 && track_line_o == '0)); // R4
   AST_ID_KNOWN: assert property (@(posedge clk) disable iff (rst)
      track_valid_o |-> track_id_o != '0); // R5

endmodule

// File: tb/sim_track_slope_classifier.sv
module sim_track_slope_classifier;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  hit = '0;
   logic [11:0] bx  = '0;
   logic        track_valid_o;
   logic [2:0]  track_id_o;
   logic [11:0] track_bx_o;
   logic [1:0]  track_line_o;

   int total = 0;
   int bad   = 0;
   int cur_bx = 1;
   bit done  = 0;
   bit sb_on = 0;

   int hq [4][$];
   int bq [4][$];
   int prev_tot = 0;
   int exp_valid = 0, exp_id = 0, exp_bx = 0, exp_line = 0;

   always #10 clk = ~clk;

   track_slope_classifier u0 (
      .clk(clk), .rst(rst), .hit_i(hit), .bx_i(bx),
      .track_valid_o(track_valid_o), .track_id_o(track_id_o),
      .track_bx_o(track_bx_o), .track_line_o(track_line_o)
   );

   // reference model: history queues, newest at the front
   always @(posedge clk) begin
      if (rst) begin
         for (int l = 0; l < 4; l++) begin hq[l].delete(); bq[l].delete(); end
         prev_tot = 0;
         exp_valid = 0; exp_id = 0; exp_bx = 0; exp_line = 0;
      end else begin
         int tot;
         int nz;
         int oldest [4];
         tot = 0; nz = 0;
         for (int l = 0; l < 4; l++) begin
            oldest[l] = 0;
            foreach (hq[l][i]) begin
               tot += hq[l][i];
               if (hq[l][i] != 0) begin
                  nz |= (1 << l);
                  oldest[l] = bq[l][i];
               end
            end
         end
         if (prev_tot < 7 && tot >= 7) begin
            exp_valid = 1;
            case (nz)
               1: exp_id = 1;
               3: exp_id = 2;
               7: exp_id = 3;
               15: exp_id = 4;
               default: exp_id = 5;
            endcase
            exp_bx = 0; exp_line = 0;
            for (int l = 0; l < 4; l++)
               if (oldest[l] != 0 && (exp_bx == 0 || oldest[l] < exp_bx)) begin
                  exp_bx = oldest[l]; exp_line = l;
               end
         end else begin
            exp_valid = 0; exp_id = 0; exp_bx = 0; exp_line = 0;
         end
         prev_tot = tot;
         for (int l = 0; l < 4; l++) begin
            hq[l].push_front(int'(hit[l]));
            bq[l].push_front(int'(bx));
            if (hq[l].size() > 8) begin
               void'(hq[l].pop_back());
               void'(bq[l].pop_back());
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   task automatic compare();
      if (!sb_on) return;
      chk(track_valid_o === exp_valid[0], "R3 valid", int'(track_valid_o), exp_valid);
      chk(track_id_o === exp_id[2:0], "R5 id", int'(track_id_o), exp_id);
      chk(track_bx_o === exp_bx[11:0], "R7 bx", int'(track_bx_o), exp_bx);
      chk(track_line_o === exp_line[1:0], "R8 line", int'(track_line_o), exp_line);
   endtask

   task automatic step(input logic [3:0] h);
      @(negedge clk);
      compare();
      rst = 1'b0;
      hit = h;
      bx  = 12'(cur_bx);
      cur_bx++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(4'b0000);
   endtask

   task automatic expect_rep(input string req, input int id, input int b, input int ln);
      chk(track_valid_o === 1'b1, {req, " strobe"}, int'(track_valid_o), 1);
      chk(track_id_o === 3'(id), {req, " id"}, int'(track_id_o), id);
      chk(track_bx_o === 12'(b), {req, " bx"}, int'(track_bx_o), b);
      chk(track_line_o === 2'(ln), {req, " line"}, int'(track_line_o), ln);
   endtask

   task automatic expect_quiet(input string req);
      chk(track_valid_o === 1'b0, {req, " no strobe"}, int'(track_valid_o), 0);
      chk(track_id_o === 3'd0, {req, " id zero"}, int'(track_id_o), 0);
   endtask

   initial begin
      int b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(track_valid_o === 1'b0, "R1 reset valid", int'(track_valid_o), 0);
      chk(track_id_o === 3'd0 && track_bx_o === 12'd0, "R1 reset id/bx", int'(track_id_o), 0);
      sb_on = 1;
      idle(3);

      // R2 R5 R9: straight track on line 0, seventh hit crosses threshold
      b0 = cur_bx;
      for (int i = 0; i < 8; i++) step(4'b0001);
      expect_quiet("R9 before report");
      step(4'b0001);
      expect_rep("R5 R9 straight", 1, b0, 0);
      for (int i = 0; i < 4; i++) begin
         step(4'b0001);
         expect_quiet("R3 held above");
      end
      idle(10);

      // R10 R6: new crossing after windows drain, irregular on line 3
      b0 = cur_bx;
      for (int i = 0; i < 7; i++) step(4'b1000);
      step(4'b0000);
      expect_quiet("R10 before report");
      step(4'b0000);
      expect_rep("R6 R10 irregular", 5, b0, 3);
      step(4'b0000);
      expect_quiet("R3 one clock");
      idle(10);

      // R8 tie: lines 0 and 1 together, four samples reach total 8
      b0 = cur_bx;
      for (int i = 0; i < 4; i++) step(4'b0011);
      step(4'b0000);
      step(4'b0000);
      expect_rep("R8 tie", 2, b0, 0);
      idle(10);

      // R7 R8: line 1 leads by two crossings
      b0 = cur_bx;
      step(4'b0010); step(4'b0010);
      for (int i = 0; i < 3; i++) step(4'b0011);
      step(4'b0000);
      step(4'b0000);
      expect_rep("R7 R8 earliest line", 2, b0, 1);
      idle(10);

      // R5: all four lines
      b0 = cur_bx;
      step(4'b1111); step(4'b1111);
      step(4'b0000); step(4'b0000);
      expect_rep("R5 all lines", 4, b0, 0);
      idle(10);

      // R5: three lines
      b0 = cur_bx;
      for (int i = 0; i < 3; i++) step(4'b0111);
      step(4'b0000); step(4'b0000);
      expect_rep("R5 three lines", 3, b0, 0);
      idle(10);

      // R1: reset in the middle discards earlier hits
      for (int i = 0; i < 5; i++) step(4'b0001);
      @(negedge clk);
      compare();
      rst = 1'b1; hit = '0;
      for (int i = 0; i < 3; i++) step(4'b0001);
      for (int i = 0; i < 4; i++) begin
         step(4'b0000);
         expect_quiet("R1 no carry over reset");
      end
      idle(10);

      // R4 and all rules under random traffic
      for (int i = 0; i < 1500; i++) begin
         logic [3:0] h;
         for (int l = 0; l < 4; l++) h[l] = (($urandom % 5) == 0);
         if (($urandom % 50) == 0) h = 4'b1111;
         step(h);
         if (track_valid_o === 1'b0)
            chk(track_bx_o === 12'd0 && track_line_o === 2'd0, "R4 quiet outputs",
                int'(track_bx_o), 0);
      end
      idle(10);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule